// File: doc/BRIEF.md
# Flash In-Application Programming Controller

This block sits between a CPU's register bus and an on-chip flash array and turns register writes into flash operations. Software loads an address-high byte, an address-low byte and a data byte, then writes a command byte. Bits 6:0 of the command byte select the operation. Bit 7 chooses how completion is reported: by polling the status register, or by a one-cycle internal interrupt pulse. The controller checks that programming is enabled and that the key bytes match what the opcode requires. It then runs the operation against a byte-wide array model. Busy is reported in the status register and on a port until the operation ends.

The operations are chip erase, block erase, sector erase, byte program, byte verify, three security-bit programs and three configuration-bit programs. The configuration bits are two user bits and a double-speed machine-cycle selection. Configuration and security bits are kept in non-volatile state. The visible copy of each configuration bit is reloaded only by a system reset. A separate power-on input models a blank part and clears all non-volatile state. Erase operations walk the address range one byte per cycle. Program, verify and configuration operations take a fixed latency.

Register selects: 0 configuration, 1 command, 2 status, 3 address high, 4 address low, 5 data.

Top module: `flash_iap_ctrl`

## Requirements
- R1: While configuration bit 6 is 0, a command write starts nothing, leaves the array unchanged and does not change the error flag.
- R2: In the command byte, bits 6:0 select the operation: 01h chip erase, 0Dh block erase, 0Bh sector erase, 0Eh program, 0Ch verify, 0Fh/03h/05h security bits 1/2/3, 09h user configuration bit, 08h double-speed bit. Bit 7 set selects interrupt completion and bit 7 clear selects polling.
- R3: Program writes the data byte to the address formed by address-high:address-low, truncated to ADDR_W bits. Verify loads the byte at that address into the data register (select 5).
- R4: Key bytes are checked for each opcode. Chip and block erase need data 55h. The security-bit programs need data AAh. Opcode 09h needs data AAh with address-high 5Ah (user bit 0) or AAh (user bit 1). Opcode 08h needs data AAh with address-high 55h. A key mismatch or an unknown opcode starts nothing and sets status bit 0. An accepted command clears status bit 0.
- R5: Status bit 2 and the busy port are 1 from the cycle after an accepted command write. They stay 1 for OP_LAT cycles for program, verify and configuration operations, and for one cycle per erased byte for erase operations.
- R6: An erase sets every byte of its range to FFh and leaves other bytes unchanged. A sector is 2^SECT_W bytes aligned around the given address. For block erase, address-high bits 7:5 = 111b select the upper half of the array and address-high bit 7 = 0 selects the lower half. Any other address-high value is a key mismatch.
- R7: Chip erase is accepted only while ext_exec_n is 0 and not all three security bits are programmed. Otherwise it is rejected as in R4.
- R8: A configuration-bit program changes only the stored bit. The outputs sc0_on, sc1_on and clk6_on, and configuration-register bits 0, 1 and 2, take the stored values only at a system reset.
- R9: In interrupt mode, done_irq pulses for exactly one cycle, in the first cycle that busy is 0 after an operation. In polling mode done_irq stays 0.
- R10: A command write while busy is dropped, sets the error flag, and does not disturb the running operation.
- R11: A power-on reset clears the stored configuration and security bits and their visible copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; reloads visible configuration bits |
| por | input | 1 | Synchronous power-on reset, active high; also clears non-volatile bits |
| ext_exec_n | input | 1 | 0 when the CPU is executing from external memory |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Registered read data, one cycle after rd_sel |
| busy | output | 1 | Operation in progress |
| done_irq | output | 1 | Completion pulse in interrupt mode |
| sc0_on | output | 1 | Visible user configuration bit 0 |
| sc1_on | output | 1 | Visible user configuration bit 1 |
| clk6_on | output | 1 | Visible double-speed machine-cycle selection |

## Verification
A command written at clock edge t raises busy after edge t. Busy falls after edge t+L, where L is OP_LAT or the erase range length, and any done_irq pulse falls one edge later. The error flag is set after edge t. Read data lags the read select by one edge. The bench drives every input on the falling edge and samples each result on the falling edge right after the rising edge that produces it. It counts the L-1 cycles of continued busy explicitly, so both ends of the busy window are checked in the exact cycle they are due.

// File: rtl/iap_pkg.sv
package iap_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_CHIP, K_BLOCK, K_SECT, K_PROG, K_VRFY,
    K_SB1, K_SB2, K_SB3, K_SC0, K_SC1, K_CLK6
  } op_kind_t;

  // opcode field values (command bits 6:0)
  localparam logic [6:0] OPC_CHIP  = 7'h01;
  localparam logic [6:0] OPC_BLOCK = 7'h0D;
  localparam logic [6:0] OPC_SECT  = 7'h0B;
  localparam logic [6:0] OPC_PROG  = 7'h0E;
  localparam logic [6:0] OPC_VRFY  = 7'h0C;
  localparam logic [6:0] OPC_SB1   = 7'h0F;
  localparam logic [6:0] OPC_SB2   = 7'h03;
  localparam logic [6:0] OPC_SB3   = 7'h05;
  localparam logic [6:0] OPC_SCX   = 7'h09;
  localparam logic [6:0] OPC_CLK6  = 7'h08;

  localparam logic [7:0] KEY_ERASE   = 8'h55;
  localparam logic [7:0] KEY_CFG     = 8'hAA;
  localparam logic [7:0] KEY_SC0_AH  = 8'h5A;
  localparam logic [7:0] KEY_SC1_AH  = 8'hAA;
  localparam logic [7:0] KEY_CLK6_AH = 8'h55;

  localparam logic [2:0] SEL_CFG  = 3'd0;
  localparam logic [2:0] SEL_CMD  = 3'd1;
  localparam logic [2:0] SEL_STAT = 3'd2;
  localparam logic [2:0] SEL_AH   = 3'd3;
  localparam logic [2:0] SEL_AL   = 3'd4;
  localparam logic [2:0] SEL_DATA = 3'd5;

  localparam int CFG_EN_BIT = 6;

endpackage

// File: rtl/iap_cmd_decode.sv
module iap_cmd_decode
  import iap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 6,
  parameter int OP_LAT = 4,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic [6:0]        opcode,
  input  logic [7:0]        key_data,
  input  logic [7:0]        key_ah,
  input  logic [7:0]        key_al,
  input  logic              ext_exec_n,
  input  logic              lock_full,
  output op_kind_t          kind,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  len
);

  localparam logic [LEN_W-1:0] LEN_CHIP  = LEN_W'(1) << ADDR_W;
  localparam logic [LEN_W-1:0] LEN_BLOCK = LEN_W'(1) << (ADDR_W - 1);
  localparam logic [LEN_W-1:0] LEN_SECT  = LEN_W'(1) << SECT_W;
  localparam logic [LEN_W-1:0] LEN_FIX   = LEN_W'(OP_LAT);

  logic [ADDR_W-1:0] addr;
  assign addr = ADDR_W'({key_ah, key_al});

  always_comb begin
    kind = K_NONE;
    base = addr;
    len  = LEN_FIX;
    case (opcode)
      OPC_CHIP: begin
        if (key_data == KEY_ERASE && !ext_exec_n && !lock_full) begin
          kind = K_CHIP;
          base = '0;
          len  = LEN_CHIP;
        end
      end
      OPC_BLOCK: begin
        len = LEN_BLOCK;
        if (key_data == KEY_ERASE) begin
          if (key_ah[7:5] == 3'b111) begin
            kind = K_BLOCK;
            base = {1'b1, {(ADDR_W-1){1'b0}}};
          end else if (!key_ah[7]) begin
            kind = K_BLOCK;
            base = '0;
          end
        end
      end
      OPC_SECT: begin
        kind = K_SECT;
        base = {addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
        len  = LEN_SECT;
      end
      OPC_PROG: kind = K_PROG;
      OPC_VRFY: kind = K_VRFY;
      OPC_SB1:  if (key_data == KEY_CFG) kind = K_SB1;
      OPC_SB2:  if (key_data == KEY_CFG) kind = K_SB2;
      OPC_SB3:  if (key_data == KEY_CFG) kind = K_SB3;
      OPC_SCX: begin
        if (key_data == KEY_CFG) begin
          if (key_ah == KEY_SC0_AH)      kind = K_SC0;
          else if (key_ah == KEY_SC1_AH) kind = K_SC1;
        end
      end
      OPC_CLK6: if (key_data == KEY_CFG && key_ah == KEY_CLK6_AH) kind = K_CLK6;
      default: kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/iap_seq.sv
module iap_seq
  import iap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_kind_t          kind_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              irq_sel_in,
  input  logic [7:0]        wdata_in,
  output logic              busy,
  output logic              done_irq,
  output logic              fin,
  output op_kind_t          kind_q,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  logic [LEN_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur;
  logic              irq_q;
  logic [7:0]        wd_q;
  logic              is_erase;

  assign is_erase  = (kind_q == K_CHIP) || (kind_q == K_BLOCK) || (kind_q == K_SECT);
  assign fin       = busy && (cnt == '0);
  assign mem_we    = busy && (is_erase || kind_q == K_PROG);
  assign mem_addr  = cur;
  assign mem_wdata = is_erase ? 8'hFF : wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done_irq <= 1'b0;
      cnt      <= '0;
      cur      <= '0;
      kind_q   <= K_NONE;
      irq_q    <= 1'b0;
      wd_q     <= '0;
    end else begin
      done_irq <= fin && irq_q;
      if (start && !busy) begin
        busy   <= 1'b1;
        cnt    <= len_in - LEN_W'(1);
        cur    <= base_in;
        kind_q <= kind_in;
        irq_q  <= irq_sel_in;
        wd_q   <= wdata_in;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - LEN_W'(1);
        if (is_erase) cur <= cur + ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/iap_flash_array.sv
module iap_flash_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/iap_nvcfg.sv
module iap_nvcfg
  import iap_pkg::*;
#(
  parameter int N_SB = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     por,
  input  logic     fin,
  input  op_kind_t kind,
  output logic     lock_full,
  output logic     sc0_on,
  output logic     sc1_on,
  output logic     clk6_on
);

  logic [N_SB-1:0] sb_q;
  logic            sc0_nv, sc1_nv, clk6_nv;

  for (genvar g = 0; g < N_SB; g++) begin : g_sb
    logic sb_bit;
    always_ff @(posedge clk) begin
      if (por)                                              sb_bit <= 1'b0;
      else if (fin && kind == op_kind_t'(int'(K_SB1) + g))  sb_bit <= 1'b1;
    end
    assign sb_q[g] = sb_bit;
  end

  assign lock_full = &sb_q;

  always_ff @(posedge clk) begin
    if (por) begin
      sc0_nv  <= 1'b0;
      sc1_nv  <= 1'b0;
      clk6_nv <= 1'b0;
    end else if (fin) begin
      if (kind == K_SC0)  sc0_nv  <= 1'b1;
      if (kind == K_SC1)  sc1_nv  <= 1'b1;
      if (kind == K_CLK6) clk6_nv <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      sc0_on  <= 1'b0;
      sc1_on  <= 1'b0;
      clk6_on <= 1'b0;
    end else if (rst) begin
      sc0_on  <= sc0_nv;
      sc1_on  <= sc1_nv;
      clk6_on <= clk6_nv;
    end
  end

endmodule

// File: rtl/flash_iap_ctrl.sv
module flash_iap_ctrl
  import iap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 6,
  parameter int OP_LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por,
  input  logic       ext_exec_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done_irq,
  output logic       sc0_on,
  output logic       sc1_on,
  output logic       clk6_on
);

  localparam int LEN_W = ADDR_W + 1;

  logic              rst_all;
  logic              cfg_en_q;
  logic [7:0]        cmd_q, ah_q, al_q, data_q;
  logic              err_q;
  logic              wr_cmd, accepted, rejected;
  op_kind_t          dec_kind, run_kind;
  logic [ADDR_W-1:0] dec_base, mem_addr;
  logic [LEN_W-1:0]  dec_len;
  logic              fin, lock_full, mem_we;
  logic [7:0]        mem_wdata, mem_rdata;

  assign rst_all  = rst | por;
  assign wr_cmd   = wr_en && (wr_sel == SEL_CMD);
  assign accepted = wr_cmd && cfg_en_q && !busy && (dec_kind != K_NONE);
  assign rejected = wr_cmd && cfg_en_q && !accepted;

  iap_cmd_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .OP_LAT(OP_LAT), .LEN_W(LEN_W)) u_dec (
    .opcode     (wr_data[6:0]),
    .key_data   (data_q),
    .key_ah     (ah_q),
    .key_al     (al_q),
    .ext_exec_n (ext_exec_n),
    .lock_full  (lock_full),
    .kind       (dec_kind),
    .base       (dec_base),
    .len        (dec_len)
  );

  iap_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst_all),
    .start      (accepted),
    .kind_in    (dec_kind),
    .base_in    (dec_base),
    .len_in     (dec_len),
    .irq_sel_in (wr_data[7]),
    .wdata_in   (data_q),
    .busy       (busy),
    .done_irq   (done_irq),
    .fin        (fin),
    .kind_q     (run_kind),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  iap_flash_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  iap_nvcfg #(.N_SB(3)) u_nv (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .fin       (fin),
    .kind      (run_kind),
    .lock_full (lock_full),
    .sc0_on    (sc0_on),
    .sc1_on    (sc1_on),
    .clk6_on   (clk6_on)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      cfg_en_q <= 1'b0;
      cmd_q    <= '0;
      ah_q     <= '0;
      al_q     <= '0;
      data_q   <= '0;
      err_q    <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_CFG:  cfg_en_q <= wr_data[CFG_EN_BIT];
          SEL_CMD:  if (cfg_en_q) cmd_q <= wr_data;
          SEL_AH:   ah_q   <= wr_data;
          SEL_AL:   al_q   <= wr_data;
          SEL_DATA: data_q <= wr_data;
          default:  ;
        endcase
      end
      if (fin && run_kind == K_VRFY) data_q <= mem_rdata;
      if (accepted)      err_q <= 1'b0;
      else if (rejected) err_q <= 1'b1;
      case (rd_sel)
        SEL_CFG:  rd_data <= {1'b0, cfg_en_q, 3'b000, clk6_on, sc1_on, sc0_on};
        SEL_CMD:  rd_data <= cmd_q;
        SEL_STAT: rd_data <= {5'b00000, busy, 1'b0, err_q};
        SEL_AH:   rd_data <= ah_q;
        SEL_AL:   rd_data <= al_q;
        SEL_DATA: rd_data <= data_q;
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/iap_chk.sv
module iap_chk
  import iap_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       por,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic       busy,
  input logic       done_irq,
  input logic       sc0_on,
  input logic       sc1_on,
  input logic       clk6_on,
  input logic       cfg_en
);

  // R1: an operation only begins from an enabled command write
  p_start_gated_r1: assert property (@(posedge clk) disable iff (rst || por)
    $rose(busy) |-> $past(wr_en && wr_sel == SEL_CMD && cfg_en));

  // R5: every operation is busy for at least two cycles
  p_busy_min_r5: assert property (@(posedge clk) disable iff (rst || por)
    $rose(busy) |=> busy);

  // R9: completion pulse coincides with the end of busy
  p_irq_edge_r9: assert property (@(posedge clk) disable iff (rst || por)
    done_irq |-> (!busy && $past(busy)));

  // R9: completion pulse lasts one cycle
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst || por)
    done_irq |=> !done_irq);

  // R8: visible configuration bits change only through a reset
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst) && !$past(por)) |-> $stable({sc0_on, sc1_on, clk6_on}));

endmodule

bind flash_iap_ctrl iap_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .por      (por),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .busy     (busy),
  .done_irq (done_irq),
  .sc0_on   (sc0_on),
  .sc1_on   (sc1_on),
  .clk6_on  (clk6_on),
  .cfg_en   (cfg_en_q)
);

// File: tb/sim_flash_iap_ctrl.sv
module sim_flash_iap_ctrl;

  localparam int CLK_PER = 10;
  localparam int LAT     = 4;
  localparam int CHIP_N  = 1024;
  localparam int BLK_N   = 512;
  localparam int SECT_N  = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1, por = 1'b1, ext_exec_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       busy, done_irq, sc0_on, sc1_on, clk6_on;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  flash_iap_ctrl #(.ADDR_W(10), .SECT_W(6), .OP_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .por(por), .ext_exec_n(ext_exec_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .busy(busy), .done_irq(done_irq),
    .sc0_on(sc0_on), .sc1_on(sc1_on), .clk6_on(clk6_on)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  task automatic setup(input logic [7:0] ah, input logic [7:0] al, input logic [7:0] d);
    wr(3'd3, ah); wr(3'd4, al); wr(3'd5, d);
  endtask

  // issue a command and check the busy window and completion pulse
  task automatic run(input logic [7:0] cmd, input int len, input string req);
    wr(3'd1, cmd);
    chk({req, " R5 busy start"}, {7'b0, busy}, 8'h01);
    repeat (len - 1) @(negedge clk);
    chk({req, " R5 busy last"}, {7'b0, busy}, 8'h01);
    @(negedge clk);
    chk({req, " R5 busy end"}, {7'b0, busy}, 8'h00);
    chk({req, " R9 irq"}, {7'b0, done_irq}, {7'b0, cmd[7]});
    @(negedge clk);
    chk({req, " R9 irq width"}, {7'b0, done_irq}, 8'h00);
  endtask

  task automatic read_byte(input logic [7:0] ah, input logic [7:0] al, output logic [7:0] v);
    setup(ah, al, 8'h00);
    run(8'h0C, LAT, "R3 verify");
    rd(3'd5, v);
  endtask

  task automatic reject(input logic [7:0] cmd, input string req);
    logic [7:0] v;
    wr(3'd1, cmd);
    chk({req, " no start"}, {7'b0, busy}, 8'h00);
    rd(3'd2, v);
    chk({req, " error flag"}, v, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 reset busy", {7'b0, busy}, 8'h00);
    chk("R11 reset cfg outs", {5'b0, clk6_on, sc1_on, sc0_on}, 8'h00);
    rd(3'd2, v); chk("R5 reset status", v, 8'h00);
  endtask

  task automatic t_chip_erase();
    logic [7:0] v;
    wr(3'd0, 8'h40);
    setup(8'h00, 8'h00, 8'h55);
    ext_exec_n = 1'b1;
    reject(8'h01, "R7 chip erase internal exec");
    ext_exec_n = 1'b0;
    setup(8'h00, 8'h00, 8'h55);
    run(8'h01, CHIP_N, "R6 chip erase poll");
    rd(3'd2, v); chk("R4 error cleared", v, 8'h00);
    read_byte(8'h01, 8'h23, v); chk("R6 chip erase byte", v, 8'hFF);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(3'd0, 8'h00);
    setup(8'h00, 8'h20, 8'h99);
    wr(3'd1, 8'h0E);
    chk("R1 disabled no busy", {7'b0, busy}, 8'h00);
    rd(3'd2, v); chk("R1 disabled no error", v, 8'h00);
    wr(3'd0, 8'h40);
    read_byte(8'h00, 8'h20, v); chk("R1 array untouched", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    setup(8'h01, 8'h23, 8'h5C);
    run(8'h8E, LAT, "R2 program irq");
    read_byte(8'h01, 8'h23, v); chk("R3 program readback", v, 8'h5C);
    read_byte(8'h05, 8'h23, v); chk("R3 address truncation", v, 8'h5C);
  endtask

  task automatic t_keys();
    setup(8'h00, 8'h00, 8'h12);
    reject(8'h0D, "R4 block erase bad data");
    setup(8'h00, 8'h00, 8'h55);
    reject(8'h02, "R4 unknown opcode");
    setup(8'h80, 8'h00, 8'h55);
    reject(8'h0D, "R6 block select invalid");
    setup(8'h5A, 8'h00, 8'h55);
    reject(8'h09, "R4 config bad data");
    setup(8'h33, 8'h00, 8'hAA);
    reject(8'h09, "R4 config bad address high");
  endtask

  task automatic t_busy_drop();
    logic [7:0] v;
    setup(8'h00, 8'h10, 8'hA1);
    wr(3'd1, 8'h0E);
    wr(3'd5, 8'h77);
    wr(3'd1, 8'h0E);
    while (busy) @(negedge clk);
    rd(3'd2, v); chk("R10 busy start error", v, 8'h01);
    read_byte(8'h00, 8'h10, v); chk("R10 first op intact", v, 8'hA1);
  endtask

  task automatic t_sector();
    logic [7:0] v;
    setup(8'h00, 8'h45, 8'h11); run(8'h0E, LAT, "R3 program");
    setup(8'h00, 8'h85, 8'h22); run(8'h0E, LAT, "R3 program");
    setup(8'h00, 8'h50, 8'h00); run(8'h0B, SECT_N, "R6 sector erase");
    read_byte(8'h00, 8'h45, v); chk("R6 sector erased", v, 8'hFF);
    read_byte(8'h00, 8'h85, v); chk("R6 next sector kept", v, 8'h22);
  endtask

  task automatic t_block();
    logic [7:0] v;
    setup(8'h03, 8'h00, 8'h33); run(8'h0E, LAT, "R3 program");
    setup(8'h01, 8'h00, 8'h44); run(8'h0E, LAT, "R3 program");
    setup(8'hE0, 8'h00, 8'h55); run(8'h8D, BLK_N, "R6 block1 erase");
    read_byte(8'h03, 8'h00, v); chk("R6 block1 erased", v, 8'hFF);
    read_byte(8'h01, 8'h00, v); chk("R6 block0 kept", v, 8'h44);
    setup(8'h00, 8'h00, 8'h55); run(8'h0D, BLK_N, "R6 block0 erase");
    read_byte(8'h01, 8'h00, v); chk("R6 block0 erased", v, 8'hFF);
  endtask

  task automatic t_config();
    logic [7:0] v;
    setup(8'h5A, 8'h00, 8'hAA); run(8'h09, LAT, "R8 sc0 program");
    chk("R8 sc0 not yet visible", {7'b0, sc0_on}, 8'h00);
    rd(3'd0, v); chk("R8 cfg read before reset", v, 8'h40);
    setup(8'hAA, 8'h00, 8'hAA); run(8'h89, LAT, "R8 sc1 program");
    setup(8'h55, 8'h00, 8'hAA); run(8'h08, LAT, "R8 clk6 program");
    chk("R8 clk6 not yet visible", {7'b0, clk6_on}, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 visible after reset", {5'b0, clk6_on, sc1_on, sc0_on}, 8'h07);
    rd(3'd0, v); chk("R8 cfg read after reset", v, 8'h07);
    wr(3'd0, 8'h40);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    setup(8'h00, 8'h10, 8'hA5); run(8'h0E, LAT, "R3 program");
    setup(8'h00, 8'h00, 8'hAA);
    run(8'h0F, LAT, "R2 sb1"); run(8'h03, LAT, "R2 sb2"); run(8'h05, LAT, "R2 sb3");
    ext_exec_n = 1'b0;
    setup(8'h00, 8'h00, 8'h55);
    reject(8'h01, "R7 chip erase locked");
    read_byte(8'h00, 8'h10, v); chk("R7 array kept when locked", v, 8'hA5);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    chk("R11 por clears cfg", {5'b0, clk6_on, sc1_on, sc0_on}, 8'h00);
    wr(3'd0, 8'h40);
    setup(8'h00, 8'h00, 8'h55);
    run(8'h01, CHIP_N, "R11 chip erase after por");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    t_reset();
    t_chip_erase();
    t_disabled();
    t_program();
    t_keys();
    t_busy_drop();
    t_sector();
    t_block();
    t_config();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule